// File: doc/BRIEF.md
# Sixteen-Cell Logic Cluster with Shared Controls

This block is one cluster of a configurable logic fabric. It holds sixteen identical logic cells. Each cell has a four-input lookup function or a one-bit adder and a single register. All cells share one small set of cluster-wide control signals. A configuration word says where each shared control comes from: one of six dedicated row lines or one of eight local signals. A second configuration word sets up each cell. The cluster decodes the selections and sends the resulting clock qualifier, enable, asynchronous clear, synchronous clear and synchronous load to the cells. It also links the cells into a carry chain and a register chain. Both chains run from cell 0 to cell 15.

Everything is clocked by one system clock `clk`. A selected "cluster clock" is a qualifier: the registers of a group load on a `clk` edge only while that group's selected clock line is high and its paired enable is high. The sharing rules of the control set are checked at all times. `cfg_illegal` is raised whenever the requested assignment breaks one of them. The device-wide reset `rst_n` is active low and asynchronous. It clears every register and takes precedence over every other control.

Top module: `lc_cluster`

## Requirements
- R1: While `rst_n` is low, every bit of `reg_out` is 0. This holds whatever the other inputs do, and it takes effect at once without waiting for a clock edge.
- R2: Each cell has a 20-bit field in `cell_cfg`; cell i uses bits [20i+19:20i]. Bits [15:0] are a truth table, bit 16 selects arithmetic mode, bit 17 picks the clock group (0 = A, 1 = B), bit 18 picks the clear group (0 = A, 1 = B) and bit 19 selects register-chain input. The cell's data is `cell_d[4i+3:4i]`, called d3..d0. In normal mode `comb_out[i]` equals the truth-table bit indexed by {d3,d2,d1,d0}.
- R3: In arithmetic mode a cell outputs d0^d1^cin on `comb_out[i]` and carries out the majority of d0, d1 and cin. A normal-mode cell passes its carry in straight to its carry out. Cell 0 takes its carry from `carry_in`, and `carry_out` is the carry out of cell 15.
- R4: `clu_cfg` holds eight 5-bit selectors. Selector k sits at bits [5k+4:5k]. Its bit 4 means "used", bit 3 means "local", and bits 2:0 are the line index. The controls are k=0 clock A, 1 clock B, 2 enable A, 3 enable B, 4 clear A, 5 clear B, 6 synchronous clear and 7 synchronous load. Bit 40 requests register packing. A register loads on a `clk` edge only when its group's clock line is high and that group's enable is high. An unused enable counts as high, and an unused clock never loads.
- R5: With chain input selected, cell i loads the register of cell i-1, and cell 0 loads `chain_in`. `chain_out` shows the register of cell 15.
- R6: When synchronous clear is asserted, every register that loads on that edge becomes 0, even if synchronous load is asserted too.
- R7: When synchronous load is asserted, every register that loads on that edge takes its d3. While synchronous load is used, group A loads without regard to enable A.
- R8: With packing requested, a register loads its d3 in place of the lookup result. `comb_out` still shows the lookup result.
- R9: An asserted asynchronous clear of group A or B clears the registers of the cells in that clear group at once, without a clock edge. Cells in the other group keep their values.
- R10: `cfg_illegal` is 1 when synchronous load and enable A are both used. Synchronous load with enable A unused is legal.
- R11: `cfg_illegal` is 1 when synchronous load is used together with packing.
- R12: `cfg_illegal` is 1 when more than four used controls select local lines. Exactly four is legal.
- R13: `cfg_illegal` is 1 when a used control selects a row index of 6 or above. An unused selector's index is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Device-wide asynchronous reset, active low |
| row_clk | input | 6 | Dedicated row control lines |
| loc_sig | input | 8 | Local control signals |
| clu_cfg | input | 41 | Control selectors and packing request |
| cell_cfg | input | 320 | Per-cell configuration, 20 bits per cell |
| cell_d | input | 64 | Per-cell data inputs, 4 bits per cell |
| carry_in | input | 1 | Carry from the previous cluster |
| chain_in | input | 1 | Register-chain input from the previous cluster |
| comb_out | output | 16 | Combinational result of each cell |
| reg_out | output | 16 | Register value of each cell |
| carry_out | output | 1 | Carry to the next cluster |
| chain_out | output | 1 | Register-chain output to the next cluster |
| cfg_illegal | output | 1 | The control assignment breaks a sharing rule |

## Verification
The lookup path is driven with two data sweeps over distinct truth tables. The adder path gets an all-ones operand plus carry, which ripples through all sixteen cells, and also a mixed pair. The register path is tried with split clock groups and a gated enable, which shows whether the groups are decoded independently. Load data patterns in which the lookup result differs from d3 show whether synchronous load, packing and clear win in the stated order. The legality flag is probed on both sides of each limit: four versus five local controls, row index 5 versus 6, and load with and without its clashing partner.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int SEL_IDX_W = 3;
    localparam int N_CTL     = 8;
    localparam int LUT_W     = 16;

    typedef enum logic [2:0] {
        CTL_CLK_A = 3'd0,
        CTL_CLK_B = 3'd1,
        CTL_EN_A  = 3'd2,
        CTL_EN_B  = 3'd3,
        CTL_CLR_A = 3'd4,
        CTL_CLR_B = 3'd5,
        CTL_SCLR  = 3'd6,
        CTL_SLOAD = 3'd7
    } ctl_id_e;

    typedef struct packed {
        logic                 used;
        logic                 is_loc;
        logic [SEL_IDX_W-1:0] idx;
    } ctl_sel_t;

    typedef struct packed {
        logic                  pack;
        ctl_sel_t [N_CTL-1:0]  sel;
    } clu_cfg_t;

    typedef struct packed {
        logic             chain;
        logic             clr_grp;
        logic             clk_grp;
        logic             arith;
        logic [LUT_W-1:0] mask;
    } cell_cfg_t;

    localparam int CLU_CFG_W  = $bits(clu_cfg_t);
    localparam int CELL_CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lc_ctl_decode.sv
module lc_ctl_decode
    import lc_pkg::*;
#(
    parameter int NROW      = 6,
    parameter int NLOC      = 8,
    parameter int MAX_LOCAL = 4
) (
    input  clu_cfg_t         cfg,
    input  logic [NROW-1:0]  row_clk,
    input  logic [NLOC-1:0]  loc_sig,
    output logic [1:0]       grp_tick,
    output logic [1:0]       grp_aclr,
    output logic             sclr,
    output logic             sload,
    output logic             illegal
);
    localparam int PAD = 1 << SEL_IDX_W;
    localparam logic [SEL_IDX_W:0] ROW_LIM = (SEL_IDX_W+1)'(NROW);
    localparam logic [SEL_IDX_W:0] LOC_LIM = (SEL_IDX_W+1)'(NLOC);

    logic [PAD-1:0]   row_pad;
    logic [PAD-1:0]   loc_pad;
    logic [N_CTL-1:0] line;
    logic [N_CTL-1:0] loc_use;
    logic [N_CTL-1:0] bad_idx;
    logic             en_a;
    logic             en_b;

    assign row_pad = PAD'(row_clk);
    assign loc_pad = PAD'(loc_sig);

    always_comb begin
        for (int k = 0; k < N_CTL; k++) begin
            line[k]    = 1'b0;
            loc_use[k] = cfg.sel[k].used & cfg.sel[k].is_loc;
            bad_idx[k] = 1'b0;
            if (cfg.sel[k].used) begin
                if (cfg.sel[k].is_loc) begin
                    line[k]    = loc_pad[cfg.sel[k].idx];
                    bad_idx[k] = ({1'b0, cfg.sel[k].idx} >= LOC_LIM);
                end else begin
                    line[k]    = row_pad[cfg.sel[k].idx];
                    bad_idx[k] = ({1'b0, cfg.sel[k].idx} >= ROW_LIM);
                end
            end
        end
    end

    // enable A is taken over while synchronous load is in use
    assign en_a = cfg.sel[CTL_SLOAD].used ? 1'b1
                : (cfg.sel[CTL_EN_A].used ? line[CTL_EN_A] : 1'b1);
    assign en_b = cfg.sel[CTL_EN_B].used ? line[CTL_EN_B] : 1'b1;

    assign grp_tick[0] = line[CTL_CLK_A] & en_a;
    assign grp_tick[1] = line[CTL_CLK_B] & en_b;
    assign grp_aclr[0] = line[CTL_CLR_A];
    assign grp_aclr[1] = line[CTL_CLR_B];
    assign sclr        = line[CTL_SCLR];
    assign sload       = line[CTL_SLOAD];

    assign illegal = (|bad_idx)
                   | ($countones(loc_use) > MAX_LOCAL)
                   | (cfg.sel[CTL_SLOAD].used & cfg.sel[CTL_EN_A].used)
                   | (cfg.sel[CTL_SLOAD].used & cfg.pack);
endmodule

// File: rtl/lc_cell.sv
module lc_cell
    import lc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             aclr,
    input  logic             sclr,
    input  logic             sload,
    input  logic             pack,
    input  logic             arith,
    input  logic             chain_sel,
    input  logic [LUT_W-1:0] mask,
    input  logic [3:0]       d,
    input  logic             cin,
    input  logic             chain_in,
    output logic             comb,
    output logic             cout,
    output logic             q
);
    logic nxt;
    logic arst_n;

    always_comb begin
        if (arith) begin
            comb = d[0] ^ d[1] ^ cin;
            cout = (d[0] & d[1]) | (cin & (d[0] ^ d[1]));
        end else begin
            comb = mask[d];
            cout = cin;
        end
    end

    always_comb begin
        if (sclr)           nxt = 1'b0;
        else if (sload)     nxt = d[3];
        else if (chain_sel) nxt = chain_in;
        else if (pack)      nxt = d[3];
        else                nxt = comb;
    end

    assign arst_n = rst_n & ~aclr;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)   q <= 1'b0;
        else if (tick) q <= nxt;
    end
endmodule

// File: rtl/lc_cluster.sv
module lc_cluster
    import lc_pkg::*;
#(
    parameter int NCELL     = 16,
    parameter int NROW      = 6,
    parameter int NLOC      = 8,
    parameter int MAX_LOCAL = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NROW-1:0]             row_clk,
    input  logic [NLOC-1:0]             loc_sig,
    input  logic [CLU_CFG_W-1:0]        clu_cfg,
    input  logic [NCELL*CELL_CFG_W-1:0] cell_cfg,
    input  logic [NCELL*4-1:0]          cell_d,
    input  logic                        carry_in,
    input  logic                        chain_in,
    output logic [NCELL-1:0]            comb_out,
    output logic [NCELL-1:0]            reg_out,
    output logic                        carry_out,
    output logic                        chain_out,
    output logic                        cfg_illegal
);
    clu_cfg_t          ccfg;
    logic [1:0]        grp_tick;
    logic [1:0]        grp_aclr;
    logic              sclr_l;
    logic              sload_l;
    logic [NCELL:0]    carry_w;
    logic [NCELL:0]    chain_w;
    logic [NCELL-1:0]  q_w;
    logic [NCELL-1:0]  cell_arith;

    assign ccfg = clu_cfg;

    lc_ctl_decode #(
        .NROW      (NROW),
        .NLOC      (NLOC),
        .MAX_LOCAL (MAX_LOCAL)
    ) dec_i (
        .cfg      (ccfg),
        .row_clk  (row_clk),
        .loc_sig  (loc_sig),
        .grp_tick (grp_tick),
        .grp_aclr (grp_aclr),
        .sclr     (sclr_l),
        .sload    (sload_l),
        .illegal  (cfg_illegal)
    );

    assign carry_w[0] = carry_in;
    assign chain_w[0] = chain_in;

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        cell_cfg_t cc;
        assign cc            = cell_cfg[i*CELL_CFG_W +: CELL_CFG_W];
        assign cell_arith[i] = cc.arith;
        assign chain_w[i+1]  = q_w[i];

        lc_cell cell_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (grp_tick[cc.clk_grp]),
            .aclr      (grp_aclr[cc.clr_grp]),
            .sclr      (sclr_l),
            .sload     (sload_l),
            .pack      (ccfg.pack),
            .arith     (cc.arith),
            .chain_sel (cc.chain),
            .mask      (cc.mask),
            .d         (cell_d[i*4 +: 4]),
            .cin       (carry_w[i]),
            .chain_in  (chain_w[i]),
            .comb      (comb_out[i]),
            .cout      (carry_w[i+1]),
            .q         (q_w[i])
        );
    end

    assign reg_out   = q_w;
    assign carry_out = carry_w[NCELL];
    assign chain_out = chain_w[NCELL];
endmodule

// File: rtl/lc_cluster_chk.sv
module lc_cluster_chk
    import lc_pkg::*;
#(
    parameter int NCELL     = 16,
    parameter int NROW      = 6,
    parameter int MAX_LOCAL = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CLU_CFG_W-1:0] clu_cfg,
    input logic [NCELL-1:0]     cell_arith,
    input logic [NCELL-1:0]     reg_out,
    input logic                 carry_in,
    input logic                 carry_out,
    input logic                 cfg_illegal
);
    clu_cfg_t         cfg;
    logic [N_CTL-1:0] loc_use;
    logic [N_CTL-1:0] bad_row;
    logic             idle;

    assign cfg = clu_cfg;

    always_comb begin
        for (int k = 0; k < N_CTL; k++) begin
            loc_use[k] = cfg.sel[k].used && cfg.sel[k].is_loc;
            bad_row[k] = cfg.sel[k].used && !cfg.sel[k].is_loc
                         && (int'(cfg.sel[k].idx) >= NROW);
        end
    end

    assign idle = !cfg.sel[CTL_CLK_A].used && !cfg.sel[CTL_CLK_B].used
               && !cfg.sel[CTL_CLR_A].used && !cfg.sel[CTL_CLR_B].used;

    AST_CARRY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_arith == '0) |-> (carry_out == carry_in)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> $stable(reg_out)); // R4
    AST_SLOAD_EN_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel[CTL_SLOAD].used && cfg.sel[CTL_EN_A].used) |-> cfg_illegal); // R10
    AST_SLOAD_PACK_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel[CTL_SLOAD].used && cfg.pack) |-> cfg_illegal); // R11
    AST_LOCAL_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(loc_use) > MAX_LOCAL) |-> cfg_illegal); // R12
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|bad_row) |-> cfg_illegal); // R13
endmodule

bind lc_cluster lc_cluster_chk #(
    .NCELL     (NCELL),
    .NROW      (NROW),
    .MAX_LOCAL (MAX_LOCAL)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clu_cfg     (clu_cfg),
    .cell_arith  (cell_arith),
    .reg_out     (reg_out),
    .carry_in    (carry_in),
    .carry_out   (carry_out),
    .cfg_illegal (cfg_illegal)
);

// File: tb/lc_cluster_tb.sv
module lc_cluster_tb_top;
    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [5:0]    row_clk;
    logic [7:0]    loc_sig;
    logic [40:0]   clu_cfg;
    logic [319:0]  cell_cfg;
    logic [63:0]   cell_d;
    logic          carry_in;
    logic          chain_in;
    logic [15:0]   comb_out;
    logic [15:0]   reg_out;
    logic          carry_out;
    logic          chain_out;
    logic          cfg_illegal;

    logic [4:0]    csel [8];
    logic          cpack;
    logic [15:0]   cmask [NC];
    logic          carith [NC];
    logic          cclk [NC];
    logic          cclr [NC];
    logic          cchain [NC];
    logic [3:0]    cd [NC];

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    assign clu_cfg = {cpack, csel[7], csel[6], csel[5], csel[4],
                      csel[3], csel[2], csel[1], csel[0]};
    for (genvar i = 0; i < NC; i++) begin : g_pack
        assign cell_cfg[i*20 +: 20] = {cchain[i], cclr[i], cclk[i], carith[i], cmask[i]};
        assign cell_d[i*4 +: 4]     = cd[i];
    end

    lc_cluster dut_i (
        .clk (clk), .rst_n (rst_n), .row_clk (row_clk), .loc_sig (loc_sig),
        .clu_cfg (clu_cfg), .cell_cfg (cell_cfg), .cell_d (cell_d),
        .carry_in (carry_in), .chain_in (chain_in), .comb_out (comb_out),
        .reg_out (reg_out), .carry_out (carry_out), .chain_out (chain_out),
        .cfg_illegal (cfg_illegal)
    );

    function automatic logic [4:0] sel(input bit u, input bit l, input int idx);
        return {u, l, 3'(idx)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_cfg();
        for (int k = 0; k < 8; k++) csel[k] = 5'd0;
        cpack = 1'b0;
        for (int i = 0; i < NC; i++) begin
            cmask[i] = 16'h0; carith[i] = 1'b0; cclk[i] = 1'b0;
            cclr[i] = 1'b0; cchain[i] = 1'b0; cd[i] = 4'h0;
        end
        row_clk = '0; loc_sig = '0; carry_in = 1'b0; chain_in = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic set_d3(input logic [15:0] pat);
        for (int i = 0; i < NC; i++) cd[i] = {pat[i], 3'b000};
    endtask

    task automatic load_pat(input logic [15:0] pat);
        clear_cfg();
        csel[0] = sel(1, 0, 0);
        csel[1] = sel(1, 0, 0);
        csel[7] = sel(1, 1, 2);
        row_clk[0] = 1'b1; loc_sig[2] = 1'b1;
        set_d3(pat);
        step();
    endtask

    task automatic t_reset();
        clear_cfg();
        rst_n = 1'b0;
        csel[0] = sel(1, 0, 0); csel[7] = sel(1, 1, 2);
        row_clk[0] = 1'b1; loc_sig[2] = 1'b1; set_d3(16'hFFFF);
        step(); step();
        chk("R1 reg held clear in reset", 32'(reg_out), 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 load after release", 32'(reg_out), 32'hFFFF);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear", 32'(reg_out), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_lut();
        logic [15:0] e;
        clear_cfg();
        for (int i = 0; i < NC; i++) begin
            cmask[i] = 16'hB6E1 ^ (16'(i) * 16'h0931);
            cd[i] = 4'(i);
        end
        #1;
        for (int i = 0; i < NC; i++) e[i] = cmask[i][cd[i]];
        chk("R2 lut sweep up", 32'(comb_out), 32'(e));
        for (int i = 0; i < NC; i++) cd[i] = 4'(15 - i);
        #1;
        for (int i = 0; i < NC; i++) e[i] = cmask[i][cd[i]];
        chk("R2 lut sweep down", 32'(comb_out), 32'(e));
    endtask

    task automatic add_case(input logic [15:0] a, input logic [15:0] b, input logic c);
        logic [16:0] s;
        for (int i = 0; i < NC; i++) begin
            carith[i] = 1'b1;
            cd[i] = {2'b00, b[i], a[i]};
        end
        carry_in = c;
        #1;
        s = 17'(a) + 17'(b) + 17'(c);
        chk("R3 sum", 32'(comb_out), 32'(s[15:0]));
        chk("R3 carry out", 32'(carry_out), 32'(s[16]));
    endtask

    task automatic t_arith();
        clear_cfg();
        add_case(16'hFFFF, 16'h0000, 1'b1);
        add_case(16'h1234, 16'h0F0F, 1'b0);
        add_case(16'h8000, 16'h8000, 1'b1);
        clear_cfg();
        carry_in = 1'b1;
        #1;
        chk("R3 normal cells pass carry", 32'(carry_out), 32'h1);
    endtask

    task automatic t_clk_en();
        do_reset();
        clear_cfg();
        csel[0] = sel(1, 0, 0); csel[2] = sel(1, 1, 0); csel[1] = sel(1, 0, 1);
        for (int i = 0; i < NC; i++) begin
            cmask[i] = 16'hFFFF; cclk[i] = i[0];
        end
        row_clk[0] = 1'b1;
        step();
        chk("R4 enable A low blocks load", 32'(reg_out), 32'h0);
        loc_sig[0] = 1'b1;
        step();
        chk("R4 group A loads only", 32'(reg_out), 32'h5555);
        row_clk[1] = 1'b1;
        step();
        chk("R4 group B unused enable", 32'(reg_out), 32'hFFFF);
    endtask

    task automatic t_chain();
        logic [3:0] bits;
        do_reset();
        clear_cfg();
        csel[0] = sel(1, 0, 0); row_clk[0] = 1'b1;
        for (int i = 0; i < NC; i++) cchain[i] = 1'b1;
        bits = 4'b1101;
        for (int s = 0; s < 4; s++) begin
            chain_in = bits[s];
            step();
        end
        chk("R5 shift after four", 32'(reg_out), 32'h000B);
        chain_in = 1'b0;
        for (int s = 0; s < 12; s++) step();
        chk("R5 shift after sixteen", 32'(reg_out), 32'hB000);
        chk("R5 chain out", 32'(chain_out), 32'h1);
    endtask

    task automatic t_sclr();
        load_pat(16'hFFFF);
        chk("R7 load all ones", 32'(reg_out), 32'hFFFF);
        csel[6] = sel(1, 1, 1); loc_sig[1] = 1'b1;
        for (int i = 0; i < NC; i++) cclk[i] = i[1];
        step();
        chk("R6 clear beats load", 32'(reg_out), 32'h0);
    endtask

    task automatic t_sload();
        clear_cfg();
        csel[0] = sel(1, 0, 0); csel[2] = sel(1, 1, 0); csel[7] = sel(1, 1, 2);
        row_clk[0] = 1'b1; loc_sig[2] = 1'b1;
        set_d3(16'hC35A);
        step();
        chk("R7 load ignores enable A", 32'(reg_out), 32'hC35A);
        chk("R10 load with enable A", 32'(cfg_illegal), 32'h1);
        csel[2] = 5'd0;
        #1;
        chk("R10 load alone legal", 32'(cfg_illegal), 32'h0);
    endtask

    task automatic t_pack();
        do_reset();
        clear_cfg();
        csel[0] = sel(1, 0, 0); row_clk[0] = 1'b1; cpack = 1'b1;
        set_d3(16'h0F0F);
        step();
        chk("R8 packed register", 32'(reg_out), 32'h0F0F);
        chk("R8 lookup unaffected", 32'(comb_out), 32'h0);
        chk("R8 packing alone legal", 32'(cfg_illegal), 32'h0);
        csel[7] = sel(1, 1, 2);
        #1;
        chk("R11 load with packing", 32'(cfg_illegal), 32'h1);
    endtask

    task automatic t_aclr();
        load_pat(16'hFFFF);
        clear_cfg();
        csel[4] = sel(1, 1, 3);
        for (int i = 0; i < NC; i++) cclr[i] = i[0];
        loc_sig[3] = 1'b1;
        #1;
        chk("R9 group A cleared at once", 32'(reg_out), 32'hAAAA);
        loc_sig[3] = 1'b0;
        step();
        chk("R9 group B kept", 32'(reg_out), 32'hAAAA);
    endtask

    task automatic t_local();
        clear_cfg();
        csel[0] = sel(1, 1, 0); csel[2] = sel(1, 1, 1);
        csel[4] = sel(1, 1, 2); csel[6] = sel(1, 1, 3);
        #1;
        chk("R12 four local legal", 32'(cfg_illegal), 32'h0);
        csel[1] = sel(1, 1, 4);
        #1;
        chk("R12 five local illegal", 32'(cfg_illegal), 32'h1);
        csel[1] = sel(1, 0, 4);
        #1;
        chk("R12 fifth from row legal", 32'(cfg_illegal), 32'h0);
    endtask

    task automatic t_row();
        clear_cfg();
        csel[0] = sel(1, 0, 5);
        #1;
        chk("R13 row 5 legal", 32'(cfg_illegal), 32'h0);
        csel[0] = sel(1, 0, 6);
        #1;
        chk("R13 row 6 illegal", 32'(cfg_illegal), 32'h1);
        csel[0] = sel(0, 0, 7);
        #1;
        chk("R13 unused index ignored", 32'(cfg_illegal), 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        clear_cfg();
        rst_n = 1'b0;
        #2;
        chk("R1 reset state", 32'(reg_out), 32'h0);
        t_reset();
        t_lut();
        t_arith();
        t_clk_en();
        t_chain();
        t_sclr();
        t_sload();
        t_pack();
        t_aclr();
        t_local();
        t_row();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule